// File: doc/BRIEF.md
# Clock Ratio Change Sequencer

This block sequences changes to the clock ratios of a clock generator. It takes a fast base clock that stands in for the PLL output. From it, the block makes two clock-enable strobes, one for the internal (core) domain and one for the peripheral domain. A frequency control register selects a multiplier and two dividers. The analog PLL is not modelled. It appears only as a selected multiplier ratio and a lock wait timed by an 8-bit settling counter, which has its own prescaler.

When a write changes the multiplier, both enables are frozen. The settling counter then counts up from the value software preset until it wraps past its maximum. At that point the new multiplier and dividers take effect together and both domains resume. A write that keeps the multiplier and changes only the dividers takes effect without any settling wait. The new ratio is picked up at the end of the divided period in progress. A bus clock output toggles on every base clock cycle, whatever the sequencer is doing.

Software reaches the block through a plain single-cycle register write port and a combinational read port. No data stream passes through the block, so it has no valid/ready interface.

Top module: `clk_ratio_seq`

## Requirements
- R1: After reset, address 0 reads 0x060 with the busy bit at 0. The internal enable pulses once every 4 base cycles and the peripheral enable once every 16.
- R2: Address 0 holds the frequency control fields. Bits [1:0] select the multiplier (00 = x1, 01 = x2, 10 = x4). Bits [4:2] hold the internal divider and bits [7:5] the peripheral divider. Divider codes are 000 = /1, 001 = /2, 010 = /3, 011 = /4 and 100 = /6. Read bit 8 of address 0 is the busy bit. The multiplier sets the rate of a strobe at base/4 (x1), base/2 (x2) or base (x4). Each enable pulses once per divisor count of that strobe.
- R3: A valid write to address 0 whose multiplier field differs from the applied one sets busy in the next cycle. The settling counter (address 2, bits [7:0]) then advances by one on each prescaler tick. Busy lasts (256 - preset) x prescale base cycles.
- R4: While busy is 1, the internal and peripheral enables both stay at 0.
- R5: The bus clock output changes level on every base clock cycle, including during settling.
- R6: When the settling counter wraps from 0xFF to 0x00, the following happen together:
  - busy clears;
  - the multiplier and both dividers from the triggering write are applied;
  - the counter stops and holds 0x00.
- R7: A valid write to address 0 that keeps the multiplier changes the divided rates without setting busy, and leaves the settling counter value unchanged.
- R8: While busy is 1, writes to every address are ignored.
- R9: A write to address 0 that carries multiplier code 11 or a divider code above 100 is dropped whole, and the previous settings stay in force.
- R10: A divider change takes effect only at the end of the period in progress. The enable pulse after the write therefore comes a full old period after the previous one.
- R11: Address 1 bits [3:1] select the counter prescale. Codes 0 to 7 give division by 1, 4, 16, 32, 64, 256, 1024 and 4096 of the base clock. Bit 0 enables the counter outside a settling period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (stands in for the PLL output) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Write address (0 frequency, 1 counter control, 2 counter value) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Combinational read data |
| int_ce_o | output | 1 | Internal-domain clock enable |
| per_ce_o | output | 1 | Peripheral-domain clock enable |
| bus_clk_o | output | 1 | Always-running bus clock (base / 2) |
| busy_o | output | 1 | Settling period in progress |

## Verification
The divided rates are measured as pulse-to-pulse intervals, which separates the three multiplier strobes and all five divider codes. Two multiplier changes use presets and prescales that give 16- and 64-cycle settling windows, so the prescaler count and the wrap point are both pinned. Inside those windows, stray writes test the write lockout, and the enables and bus clock are watched cycle by cycle. A divider-only write tests the path with no settling wait, including that the counter value survives it. A reserved code tests write rejection. A divider change written on the cycle of an enable pulse shows whether the period in progress is cut short.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  localparam int ADDR_FREQ = 0;
  localparam int ADDR_TCTL = 1;
  localparam int ADDR_TCNT = 2;

  typedef struct packed {
    logic [2:0] pdiv;
    logic [2:0] idiv;
    logic [1:0] mult;
  } freq_t;

  localparam freq_t FREQ_RST = '{pdiv: 3'b011, idiv: 3'b000, mult: 2'b00};

  function automatic logic div_code_ok(input logic [2:0] code);
    return code <= 3'b100;
  endfunction

  function automatic logic mult_code_ok(input logic [1:0] code);
    return code != 2'b11;
  endfunction

  // divisor minus one for a divider code
  function automatic logic [2:0] div_limit(input logic [2:0] code);
    case (code)
      3'b000:  return 3'd0;
      3'b001:  return 3'd1;
      3'b010:  return 3'd2;
      3'b011:  return 3'd3;
      default: return 3'd5;
    endcase
  endfunction

  // prescale terminal count for a prescaler code
  function automatic logic [11:0] presc_limit(input logic [2:0] sel);
    case (sel)
      3'd0:    return 12'd0;
      3'd1:    return 12'd3;
      3'd2:    return 12'd15;
      3'd3:    return 12'd31;
      3'd4:    return 12'd63;
      3'd5:    return 12'd255;
      3'd6:    return 12'd1023;
      default: return 12'd4095;
    endcase
  endfunction

endpackage

// File: rtl/pll_strobe_gen.sv
module pll_strobe_gen #(
  parameter int PH_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freeze,
  input  logic [1:0] mult,
  output logic       stb
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || freeze) phase_q <= '0;
    else                  phase_q <= phase_q + 1'b1;
  end

  always_comb begin
    case (mult)
      2'b10:   stb = 1'b1;
      2'b01:   stb = ~phase_q[0];
      default: stb = (phase_q == '0);
    endcase
    if (freeze) stb = 1'b0;
  end
endmodule

// File: rtl/ratio_div.sv
module ratio_div #(
  parameter int LIM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             freeze,
  input  logic [LIM_W-1:0] req_lim,
  output logic             ce
);
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_q;
  logic             wrap;

  assign wrap = stb && (cnt_q == lim_q);
  assign ce   = wrap && !freeze;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (freeze) begin
      cnt_q <= '0;
      lim_q <= req_lim;
    end else if (wrap) begin
      cnt_q <= '0;
      lim_q <= req_lim;   // new ratio only at a period boundary
    end else if (stb) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer
  import clkseq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [2:0]       psel,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = run && (pre_q == PRE_W'(presc_limit(psel)));
  assign ovf  = tick && (cnt_q == {CNT_W{1'b1}});
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pre_q <= '0;
    else if (tick)      pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/clk_ratio_seq.sv
module clk_ratio_seq
  import clkseq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              int_ce_o,
  output logic              per_ce_o,
  output logic              bus_clk_o,
  output logic              busy_o
);
  localparam int FREQ_W = $bits(freq_t);
  localparam int N_DOM  = 2;

  freq_t            freq_q, pend_q, wr_freq, eff_freq;
  logic             busy_q, ten_q, bus_q;
  logic [2:0]       psel_q;
  logic [CNT_W-1:0] settle_cnt;
  logic             settle_ovf, pll_stb, wr_ok;
  logic             wr_f, wr_c, wr_n;
  logic [2:0]       dom_lim [N_DOM];
  logic [N_DOM-1:0] dom_ce;

  assign wr_freq = freq_t'(wr_data[FREQ_W-1:0]);
  assign wr_ok   = mult_code_ok(wr_freq.mult) && div_code_ok(wr_freq.idiv)
                && div_code_ok(wr_freq.pdiv);
  assign wr_f = wr_en && !busy_q && (wr_addr == ADDR_W'(ADDR_FREQ)) && wr_ok;
  assign wr_c = wr_en && !busy_q && (wr_addr == ADDR_W'(ADDR_TCTL));
  assign wr_n = wr_en && !busy_q && (wr_addr == ADDR_W'(ADDR_TCNT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q <= FREQ_RST;
      pend_q <= FREQ_RST;
      busy_q <= 1'b0;
      ten_q  <= 1'b0;
      psel_q <= '0;
    end else begin
      if (wr_f) begin
        if (wr_freq.mult != freq_q.mult) begin
          pend_q <= wr_freq;
          busy_q <= 1'b1;
        end else begin
          freq_q <= wr_freq;
        end
      end
      if (wr_c) begin
        ten_q  <= wr_data[0];
        psel_q <= wr_data[3:1];
      end
      if (busy_q && settle_ovf) begin
        busy_q <= 1'b0;
        freq_q <= pend_q;
        ten_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_q <= 1'b0;
    else        bus_q <= ~bus_q;
  end

  settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy_q || ten_q), .psel(psel_q),
    .load(wr_n), .load_val(wr_data[CNT_W-1:0]),
    .cnt(settle_cnt), .ovf(settle_ovf)
  );

  // during settling the dividers preload the pending ratios
  assign eff_freq   = busy_q ? pend_q : freq_q;
  assign dom_lim[0] = div_limit(eff_freq.idiv);
  assign dom_lim[1] = div_limit(eff_freq.pdiv);

  pll_strobe_gen u_pll (
    .clk(clk), .rst_n(rst_n), .freeze(busy_q), .mult(freq_q.mult), .stb(pll_stb)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    ratio_div u_div (
      .clk(clk), .rst_n(rst_n), .stb(pll_stb), .freeze(busy_q),
      .req_lim(dom_lim[d]), .ce(dom_ce[d])
    );
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(ADDR_FREQ): rd_data = DATA_W'({busy_q, freq_q});
      ADDR_W'(ADDR_TCTL): rd_data = DATA_W'({psel_q, ten_q});
      ADDR_W'(ADDR_TCNT): rd_data = DATA_W'(settle_cnt);
      default:            rd_data = '0;
    endcase
  end

  assign int_ce_o  = dom_ce[0];
  assign per_ce_o  = dom_ce[1];
  assign bus_clk_o = bus_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/clk_ratio_seq_chk.sv
module clk_ratio_seq_chk #(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy,
  input logic              int_ce,
  input logic              per_ce,
  input logic              bus_clk,
  input logic [CNT_W-1:0]  settle_cnt,
  input logic [7:0]        freq_val
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!int_ce && !per_ce));

  assert_bus_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (bus_clk != $past(bus_clk)));

  assert_busy_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $rose(busy)) |-> $past(wr_en && (wr_addr == '0)));

  assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $fell(busy)) |-> (settle_cnt == '0));

  assert_locked_freq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && busy && $past(busy)) |-> $stable(freq_val));
endmodule

bind clk_ratio_seq clk_ratio_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy_o),
  .int_ce(int_ce_o), .per_ce(per_ce_o), .bus_clk(bus_clk_o),
  .settle_cnt(settle_cnt), .freq_val(freq_q)
);

// File: tb/clk_ratio_seq_tb_top.sv
module clk_ratio_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        int_ce, per_ce, bus_clk, busy;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  clk_ratio_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .int_ce_o(int_ce), .per_ce_o(per_ce),
    .bus_clk_o(bus_clk), .busy_o(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; drives one write across the next posedge
  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic period(input bit sel_per, output int p);
    int guard = 0;
    while (!(sel_per ? per_ce : int_ce) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    p = 0;
    do begin
      @(negedge clk); p++;
    end while (!(sel_per ? per_ce : int_ce) && p < 5000);
  endtask

  // counts busy cycles; optional stray writes at offsets 3 and 4
  task automatic watch_settle(input bit stray, output int nbusy);
    logic [15:0] d;
    nbusy = 0;
    for (int i = 0; i < 6000; i++) begin
      if (busy) begin
        nbusy++;
        check("R4 enables frozen", {int_ce, per_ce}, 0);
      end
      if (stray && i == 3) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0000; end
      if (stray && i == 4) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0011; end
      if (stray && i == 5) begin
        wr_en = 1'b0;
        reg_rd(2'd0, d);
        check("R2 busy bit", d[8], 1);
      end
      if (!busy && i > 0) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [15:0] d; int p;
    reg_rd(2'd0, d);
    check("R1 freq reset", d, 16'h0060);
    check("R1 busy reset", busy, 0);
    period(1'b0, p); check("R1 int period", p, 4);
    period(1'b1, p); check("R1 per period", p, 16);
  endtask

  task automatic t_bus_clk;
    logic prev = bus_clk;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R5 bus clock toggles", bus_clk, !prev);
      prev = bus_clk;
    end
  endtask

  task automatic t_reserved;
    logic [15:0] d; int p;
    reg_wr(2'd0, 16'h0074);   // idiv 101
    reg_wr(2'd0, 16'h0063);   // mult 11
    reg_wr(2'd0, 16'h00E0);   // pdiv 111
    reg_rd(2'd0, d);
    check("R9 reserved rejected", d, 16'h0060);
    check("R9 no settle", busy, 0);
    period(1'b0, p); check("R9 int period kept", p, 4);
  endtask

  task automatic t_div_only;
    logic [15:0] d; int p;
    reg_wr(2'd2, 16'h0033);
    reg_wr(2'd0, 16'h0044);   // x1, int /2, per /3
    check("R7 no busy", busy, 0);
    reg_rd(2'd2, d);
    check("R7 counter untouched", d, 16'h0033);
    period(1'b0, p); check("R7 int /2 at x1", p, 8);
    period(1'b1, p); check("R2 per /3 at x1", p, 12);
  endtask

  task automatic t_mult_fast;
    logic [15:0] d; int p, nb;
    reg_wr(2'd1, 16'h0000);   // enable 0, prescale /1
    reg_wr(2'd2, 16'h00F0);
    reg_wr(2'd0, 16'h0066);   // x4, int /2, per /4
    watch_settle(1'b1, nb);
    check("R3 settle length /1", nb, 16);
    reg_rd(2'd0, d);
    check("R6 R8 applied settings", d, 16'h0066);
    reg_rd(2'd2, d);
    check("R6 counter wrapped", d, 0);
    repeat (20) @(negedge clk);
    reg_rd(2'd2, d);
    check("R6 counter stopped", d, 0);
    period(1'b0, p); check("R6 int /2 at x4", p, 2);
    period(1'b1, p); check("R6 per /4 at x4", p, 4);
  endtask

  task automatic t_mult_presc;
    logic [15:0] d; int p, nb;
    reg_wr(2'd1, 16'h0002);   // prescale /4
    reg_rd(2'd1, d);
    check("R11 control readback", d, 16'h0002);
    reg_wr(2'd2, 16'h00F0);
    reg_wr(2'd0, 16'h0064);   // back to x1
    watch_settle(1'b0, nb);
    check("R11 settle length /4", nb, 64);
    period(1'b0, p); check("R6 int /2 at x1", p, 8);
    period(1'b1, p); check("R6 per /4 at x1", p, 16);
  endtask

  task automatic t_boundary;
    int p, nb, gap;
    reg_wr(2'd1, 16'h0000);
    reg_wr(2'd2, 16'h00F0);
    reg_wr(2'd0, 16'h0072);   // x4, int /6
    watch_settle(1'b0, nb);
    period(1'b0, p); check("R2 int /6 at x4", p, 6);
    while (!int_ce) @(negedge clk);
    reg_wr(2'd0, 16'h0062);   // int /1, written on a pulse cycle
    gap = 1;
    while (!int_ce && gap < 100) begin @(negedge clk); gap++; end
    check("R10 old period completes", gap, 6);
    @(negedge clk);
    check("R10 new ratio next", int_ce, 1);
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus_clk();
    t_reserved();
    t_div_only();
    t_mult_fast();
    t_mult_presc();
    t_boundary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule